// File: doc/BRIEF.md
# Strided Tile Address Generator

This unit turns one tile request into a stream of element addresses. A request carries a 2-D tensor descriptor (base address, shape, memory strides in elements, per-tile-axis traversal steps, and an axis swap selecting the dimension map) plus a tile index. The unit walks every element of one statically sized tile, which is 2^T0_LOG2 by 2^T1_LOG2, at one element per cycle. For each element it emits the memory address and an in-bounds flag. On loads it also emits a fill indication with the selected padding bit pattern. On stores it emits a write mask.

The traversal step along a tile axis is separate from the tile size. A step equal to the tile size partitions the tensor. A larger step leaves gaps between tiles, and a smaller one makes tiles overlap. Tiles at the far edge may stick out of the tensor. Those lanes are padded or masked instead of being dropped. The unit also reports the index-space extents of the accepted descriptor. A tile index outside that space raises an error, and no element is emitted for it.

Top module: `tile_addr_gen`

## Requirements
- R1: The address of the element at tensor coordinate (c0, c1) is base + c0*mstride0 + c1*mstride1, truncated to AW bits.
- R2: Tile element (k0, k1) at tile index (I0, I1) lies at position I0*tstep0 + k0 along tile axis 0 and at I1*tstep1 + k1 along tile axis 1. This holds for steps below, equal to and above the tile size.
- R3: From the cycle after a request is accepted until the next acceptance, ext0/ext1 show ceil(shape/tstep) for each tile axis, using the tensor dimension that axis is mapped to. After reset they show 0.
- R4: With swap=0, tile axis 0 maps to tensor dimension 0 and tile axis 1 to tensor dimension 1. With swap=1, tile axis 0 maps to tensor dimension 1 and tile axis 1 to tensor dimension 0.
- R5: out_inb is 1 exactly when c0 < shape0 and c1 < shape1. On a load with padding enabled, an out-of-bounds lane raises out_fill and drives out_fill_val by pad_sel: 0 gives 0x00000000, 1 gives 0x80000000, 2 gives 0x7FC00000, 3 gives 0x7F800000, 4 gives 0xFF800000, and 5 to 7 give 0x00000000. In every other case out_fill is 0 and out_fill_val is 0.
- R6: When padding is disabled, out_fill stays 0 on every lane and pad_sel has no effect on any output.
- R7: On a store, out_wmask equals out_inb and out_fill is 0. On a load, out_wmask is 0.
- R8: A request whose index has I*tstep >= mapped shape on either axis raises err for exactly the one cycle after acceptance. It emits no element, and the extents are still updated.
- R9: Elements come out in row-major tile order with k1 varying fastest. out_last is set only on element (T0-1, T1-1). The outputs hold steady while out_valid is high and out_ready is low.
- R10: req_ready is low exactly while a tile is being emitted. The first element appears in the cycle after acceptance, and a request offered while the unit is busy is not taken until req_ready is high.
- R11: After reset, req_ready is 1 and out_valid, err, ext0 and ext1 are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Unit idle, request can be taken |
| req_store | input | 1 | 1 = store (mask), 0 = load (pad) |
| req_pad_en | input | 1 | Padding configured for loads |
| req_pad_sel | input | 3 | Padding pattern select |
| req_swap | input | 1 | Dimension map: 0 identity, 1 swapped |
| req_base | input | AW | Base element address |
| req_shape0 | input | DW | Tensor extent, dimension 0 |
| req_shape1 | input | DW | Tensor extent, dimension 1 |
| req_mstride0 | input | DW | Memory stride, dimension 0 |
| req_mstride1 | input | DW | Memory stride, dimension 1 |
| req_tstep0 | input | DW | Traversal step, tile axis 0 |
| req_tstep1 | input | DW | Traversal step, tile axis 1 |
| req_idx0 | input | DW | Tile index, axis 0 |
| req_idx1 | input | DW | Tile index, axis 1 |
| ext0 | output | DW | Index-space extent, tile axis 0 |
| ext1 | output | DW | Index-space extent, tile axis 1 |
| err | output | 1 | Illegal tile index pulse |
| out_valid | output | 1 | Element available |
| out_ready | input | 1 | Consumer takes element |
| out_addr | output | AW | Element address |
| out_inb | output | 1 | Element inside tensor |
| out_wmask | output | 1 | Store write enable |
| out_fill | output | 1 | Load lane to be replaced |
| out_fill_val | output | 32 | Padding bit pattern |
| out_last | output | 1 | Final element of tile |

## Verification
A corrupted element counter appears at once as a wrong address on the very next emitted element. It also moves out_last, which ends the stream early or late, and the per-cycle comparison of out_valid and req_ready catches that in the same cycle. A wrong latched descriptor field shows up on the first element that depends on it. Edge tiles with partial overlap, swapped axes and the illegal-index path are used so that a mix-up between the shape and step of each axis becomes visible in the address, in the in-bounds flag or in the extents one cycle after acceptance.

// File: rtl/tile_addr_gen.sv
module tile_addr_gen #(
  parameter int AW = 32,
  parameter int DW = 16,
  parameter int T0_LOG2 = 2,
  parameter int T1_LOG2 = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_store,
  input  logic          req_pad_en,
  input  logic [2:0]    req_pad_sel,
  input  logic          req_swap,
  input  logic [AW-1:0] req_base,
  input  logic [DW-1:0] req_shape0,
  input  logic [DW-1:0] req_shape1,
  input  logic [DW-1:0] req_mstride0,
  input  logic [DW-1:0] req_mstride1,
  input  logic [DW-1:0] req_tstep0,
  input  logic [DW-1:0] req_tstep1,
  input  logic [DW-1:0] req_idx0,
  input  logic [DW-1:0] req_idx1,
  output logic [DW-1:0] ext0,
  output logic [DW-1:0] ext1,
  output logic          err,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [AW-1:0] out_addr,
  output logic          out_inb,
  output logic          out_wmask,
  output logic          out_fill,
  output logic [31:0]   out_fill_val,
  output logic          out_last
);
  localparam int PW = 2 * DW;
  localparam int CW = PW + 1;
  localparam int OW = CW + DW;
  localparam logic [DW-1:0] K0_MAX = DW'((1 << T0_LOG2) - 1);
  localparam logic [DW-1:0] K1_MAX = DW'((1 << T1_LOG2) - 1);

  logic          busy, err_q, store_q, pad_en_q, swap_q;
  logic [2:0]    pad_sel_q;
  logic [AW-1:0] base_q;
  logic [DW-1:0] shp0_q, shp1_q, ms0_q, ms1_q, ts0_q, ts1_q, ix0_q, ix1_q;
  logic [DW-1:0] k0, k1, ext0_q, ext1_q;

  wire accept = req_valid && !busy;

  // shape seen by each tile axis under the dimension map
  wire [DW-1:0] sa_req = req_swap ? req_shape1 : req_shape0;
  wire [DW-1:0] sb_req = req_swap ? req_shape0 : req_shape1;
  wire [PW-1:0] start_a = PW'(req_idx0) * PW'(req_tstep0);
  wire [PW-1:0] start_b = PW'(req_idx1) * PW'(req_tstep1);
  wire legal = (start_a < PW'(sa_req)) && (start_b < PW'(sb_req));
  wire [PW-1:0] ext_a = (PW'(sa_req) + PW'(req_tstep0) - PW'(1)) / PW'(req_tstep0);
  wire [PW-1:0] ext_b = (PW'(sb_req) + PW'(req_tstep1) - PW'(1)) / PW'(req_tstep1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; err_q <= 1'b0; store_q <= 1'b0; pad_en_q <= 1'b0;
      swap_q <= 1'b0; pad_sel_q <= '0; base_q <= '0;
      shp0_q <= '0; shp1_q <= '0; ms0_q <= '0; ms1_q <= '0;
      ts0_q <= '0; ts1_q <= '0; ix0_q <= '0; ix1_q <= '0;
      k0 <= '0; k1 <= '0; ext0_q <= '0; ext1_q <= '0;
    end else begin
      err_q <= accept && !legal;
      if (accept) begin
        busy <= legal;
        store_q <= req_store; pad_en_q <= req_pad_en; pad_sel_q <= req_pad_sel;
        swap_q <= req_swap; base_q <= req_base;
        shp0_q <= req_shape0; shp1_q <= req_shape1;
        ms0_q <= req_mstride0; ms1_q <= req_mstride1;
        ts0_q <= req_tstep0; ts1_q <= req_tstep1;
        ix0_q <= req_idx0; ix1_q <= req_idx1;
        k0 <= '0; k1 <= '0;
        ext0_q <= DW'(ext_a); ext1_q <= DW'(ext_b);
      end else if (busy && out_ready) begin
        if (k1 == K1_MAX) begin
          k1 <= '0;
          k0 <= k0 + DW'(1);
          if (k0 == K0_MAX) busy <= 1'b0;
        end else begin
          k1 <= k1 + DW'(1);
        end
      end
    end
  end

  wire [CW-1:0] pa = CW'(PW'(ix0_q) * PW'(ts0_q)) + CW'(k0);
  wire [CW-1:0] pb = CW'(PW'(ix1_q) * PW'(ts1_q)) + CW'(k1);
  wire [CW-1:0] c0 = swap_q ? pb : pa;
  wire [CW-1:0] c1 = swap_q ? pa : pb;
  wire [OW-1:0] off0 = OW'(c0) * OW'(ms0_q);
  wire [OW-1:0] off1 = OW'(c1) * OW'(ms1_q);

  logic [31:0] pad_pat;
  always_comb begin
    case (pad_sel_q)
      3'd1:    pad_pat = 32'h8000_0000;
      3'd2:    pad_pat = 32'h7FC0_0000;
      3'd3:    pad_pat = 32'h7F80_0000;
      3'd4:    pad_pat = 32'hFF80_0000;
      default: pad_pat = 32'h0000_0000;
    endcase
  end

  assign req_ready    = !busy;
  assign out_valid    = busy;
  assign err          = err_q;
  assign ext0         = ext0_q;
  assign ext1         = ext1_q;
  assign out_inb      = (c0 < CW'(shp0_q)) && (c1 < CW'(shp1_q));
  assign out_addr     = base_q + AW'(off0) + AW'(off1);
  assign out_wmask    = busy && store_q && out_inb;
  assign out_fill     = busy && !store_q && pad_en_q && !out_inb;
  assign out_fill_val = out_fill ? pad_pat : 32'h0;
  assign out_last     = busy && (k0 == K0_MAX) && (k1 == K1_MAX);

  assert_busy_blocks_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !req_ready);
  assert_hold_under_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_last)));
  assert_last_ends_tile_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> !out_valid);
  assert_err_no_stream_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!out_valid && $past(req_valid && req_ready)));
  assert_err_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);
  assert_mask_fill_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_wmask && out_fill));
endmodule

// File: tb/tile_addr_gen_tb.sv
module tile_addr_gen_tb_top;
  localparam int AW = 32, DW = 16, T0 = 4, T1 = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic req_valid = 0, req_store = 0, req_pad_en = 0, req_swap = 0, out_ready = 0;
  logic [2:0] req_pad_sel = 0;
  logic [AW-1:0] req_base = 0;
  logic [DW-1:0] req_shape0 = 0, req_shape1 = 0, req_mstride0 = 0, req_mstride1 = 0;
  logic [DW-1:0] req_tstep0 = 1, req_tstep1 = 1, req_idx0 = 0, req_idx1 = 0;
  logic req_ready, err, out_valid, out_inb, out_wmask, out_fill, out_last;
  logic [DW-1:0] ext0, ext1;
  logic [AW-1:0] out_addr;
  logic [31:0] out_fill_val;

  tile_addr_gen #(.AW(AW), .DW(DW), .T0_LOG2(2), .T1_LOG2(1)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_store(req_store), .req_pad_en(req_pad_en), .req_pad_sel(req_pad_sel),
    .req_swap(req_swap), .req_base(req_base), .req_shape0(req_shape0),
    .req_shape1(req_shape1), .req_mstride0(req_mstride0), .req_mstride1(req_mstride1),
    .req_tstep0(req_tstep0), .req_tstep1(req_tstep1), .req_idx0(req_idx0),
    .req_idx1(req_idx1), .ext0(ext0), .ext1(ext1), .err(err), .out_valid(out_valid),
    .out_ready(out_ready), .out_addr(out_addr), .out_inb(out_inb), .out_wmask(out_wmask),
    .out_fill(out_fill), .out_fill_val(out_fill_val), .out_last(out_last));

  typedef struct packed {
    logic [31:0] addr; logic inb; logic wmask; logic fill; logic [31:0] fv; logic last;
  } elem_t;

  elem_t q[$];
  int checks = 0, fails = 0, cycles = 0;
  bit running = 0, exp_err = 0, always_ready = 0;
  int exp_e0 = 0, exp_e1 = 0;

  task automatic chk(string req, longint got, longint exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h (t=%0t)", req, got, exp, $time);
    end
  endtask

  function automatic logic [31:0] pad_of(int sel);
    case (sel)
      1: return 32'h80000000;
      2: return 32'h7FC00000;
      3: return 32'h7F800000;
      4: return 32'hFF800000;
      default: return 32'h0;
    endcase
  endfunction

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // per-cycle comparison against the reference queue
  initial begin
    forever begin
      @(negedge clk);
      cycles++;
      if (cycles > 150000) begin
        fails++;
        $display("FAIL watchdog: got %0d expected <150000 cycles", cycles);
        finish_run();
      end
      if (running) begin
        chk("R10 out_valid", out_valid, q.size() > 0);
        chk("R10 req_ready", req_ready, q.size() == 0);
        chk("R8 err", err, exp_err);
        exp_err = 0;
        chk("R3 ext0", ext0, exp_e0);
        chk("R3 ext1", ext1, exp_e1);
        if (out_valid && q.size() > 0) begin
          chk("R1 addr", out_addr, q[0].addr);
          chk("R5 inb", out_inb, q[0].inb);
          chk("R7 wmask", out_wmask, q[0].wmask);
          chk("R6 fill", out_fill, q[0].fill);
          chk("R5 fill_val", out_fill_val, q[0].fv);
          chk("R9 last", out_last, q[0].last);
        end
        out_ready = always_ready ? 1'b1 : ($urandom_range(0, 3) != 0);
        if (out_valid && out_ready && q.size() > 0) void'(q.pop_front());
      end
    end
  end

  task automatic issue(bit st, bit pen, int psel, bit sw, longint base,
                       int s0, int s1, int m0, int m1, int t0s, int t1s, int i0, int i1);
    int sa, sb;
    @(negedge clk);
    req_store = st; req_pad_en = pen; req_pad_sel = 3'(psel); req_swap = sw;
    req_base = AW'(base); req_shape0 = DW'(s0); req_shape1 = DW'(s1);
    req_mstride0 = DW'(m0); req_mstride1 = DW'(m1); req_tstep0 = DW'(t0s);
    req_tstep1 = DW'(t1s); req_idx0 = DW'(i0); req_idx1 = DW'(i1);
    req_valid = 1;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    sa = sw ? s1 : s0;
    sb = sw ? s0 : s1;
    exp_e0 = (sa + t0s - 1) / t0s;
    exp_e1 = (sb + t1s - 1) / t1s;
    if (i0 * t0s >= sa || i1 * t1s >= sb) exp_err = 1;
    else begin
      for (int a = 0; a < T0; a++) begin
        for (int b = 0; b < T1; b++) begin
          elem_t e;
          longint pa, pb, c0, c1;
          pa = longint'(i0) * t0s + a;
          pb = longint'(i1) * t1s + b;
          c0 = sw ? pb : pa;
          c1 = sw ? pa : pb;
          e.addr = 32'((base + c0 * m0 + c1 * m1) & 64'hFFFFFFFF);
          e.inb = (c0 < s0) && (c1 < s1);
          e.wmask = st && e.inb;
          e.fill = !st && pen && !e.inb;
          e.fv = e.fill ? pad_of(psel) : 32'h0;
          e.last = (a == T0 - 1) && (b == T1 - 1);
          q.push_back(e);
        end
      end
    end
    @(negedge clk);
    req_valid = 0;
    req_pad_sel = 3'd5;
  endtask

  task automatic drain();
    while (q.size() > 0 || out_valid) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset values
    chk("R11 req_ready", req_ready, 1);
    chk("R11 out_valid", out_valid, 0);
    chk("R11 err", err, 0);
    chk("R11 ext0", ext0, 0);
    chk("R11 ext1", ext1, 0);
    rst_n = 1;
    @(negedge clk);
    running = 1;
    // R2 partition edge tile, partial in both axes, zero pad (R5)
    issue(0, 1, 0, 0, 32'h1000, 10, 5, 5, 1, 4, 2, 2, 2);
    drain();
    // R2 gaps between tiles
    issue(0, 1, 3, 0, 32'h2000, 64, 16, 16, 1, 5, 3, 1, 4);
    // R2 overlapping tiles, last tile partly outside, NaN pad; back-to-back (R10)
    issue(0, 1, 2, 0, 32'h40, 8, 8, 8, 1, 1, 1, 7, 7);
    // R4 swapped axes, far corner tile
    issue(0, 1, 1, 1, 32'h0, 64, 16, 16, 1, 4, 2, 3, 31);
    // R4 swapped, partial edge with -Inf pad
    issue(0, 1, 4, 1, 32'h300, 6, 9, 9, 1, 4, 4, 2, 1);
    drain();
    // R7 store with masked edge lanes
    issue(1, 1, 2, 0, 32'h5000, 6, 3, 3, 1, 4, 2, 1, 1);
    // R6 padding disabled on an edge tile
    issue(0, 0, 3, 0, 32'h5000, 6, 3, 3, 1, 4, 2, 1, 1);
    // R5 reserved select gives zero
    issue(0, 1, 7, 0, 32'h5000, 6, 3, 3, 1, 4, 2, 1, 1);
    drain();
    // R8 illegal index on axis 0, then on axis 1 with swap
    issue(0, 1, 0, 0, 32'h0, 10, 5, 5, 1, 4, 2, 3, 0);
    issue(0, 1, 0, 1, 32'h0, 64, 16, 16, 1, 4, 2, 0, 32);
    // R8 boundary: last legal index
    issue(0, 1, 0, 1, 32'h0, 64, 16, 16, 1, 4, 2, 3, 31);
    drain();
    // R1 large strides with address wrap
    issue(1, 0, 0, 0, 32'hFFFF_FF00, 300, 300, 1000, 3, 4, 2, 10, 20);
    // R9 full-speed consumer
    always_ready = 1;
    issue(0, 1, 1, 0, 32'h100, 16, 16, 16, 1, 4, 2, 3, 7);
    drain();
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule